// File: doc/BRIEF.md
# Banked Prefetch Request Scheduler

The scheduler sits between a processor core and a word-interleaved memory built from several independent banks. The core hands it prefetch requests, each naming a destination slot, a byte address and a load width with its sign rule. Requests are accepted into a small ordered queue and the core carries on executing while they wait. A queued request leaves the queue as soon as the bank that owns its address is idle. Requests for different banks therefore overlap, and a request whose bank is free may overtake an older one whose bank is still busy.

Each bank keeps at most one read open. The bank sends a single-cycle read strobe with the word-aligned address and waits for an acknowledge carrying the data word and an error flag. The scheduler extracts the requested field from the returned word and holds the result in that bank until the completion port delivers it to the slot. A memory error never interrupts the core. It comes back as a fault flag on that slot's completion, so the core only reacts when it actually consumes the value.

Top module: `pf_sched`

## Requirements
- R1: `req_ready_o` is low exactly while the queue holds QUEUE_DEPTH entries. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. While ready is low the core holds its request, and the request is accepted once space frees.
- R2: A request is served by bank `(addr >> 2) mod NUM_BANKS`, and only that bank's read strobe carries it.
- R3: Each bank has at most one read open. Its `mem_req_o` bit is a one-cycle pulse with the address word-aligned. The bank takes no new request until its acknowledge has arrived and its completion has been delivered.
- R4: Reads to different banks are open at the same time.
- R5: Of the queued requests whose bank is idle, the oldest goes first, at most one per cycle. Requests to the same bank leave in arrival order. A younger request to an idle bank passes an older request whose bank is busy.
- R6: Each completion is a single-cycle `rsp_valid_o` pulse carrying slot, data and fault. When several banks hold results, the lowest-numbered bank is delivered first.
- R7: Type code 0 returns the whole word. Code 1 returns a zero-extended halfword and code 2 a sign-extended halfword, taken from bits 31:16 when address bit 1 is set and from bits 15:0 otherwise. Code 3 returns a zero-extended byte and code 4 a sign-extended byte, taken from byte lane `addr[1:0]` (lane 0 = bits 7:0). Codes 5 to 7 behave as code 0.
- R8: An acknowledge with the error flag set completes that slot with fault = 1 and data = 0. Other requests are unaffected.
- R9: After reset, ready is high and no read strobe or completion is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Prefetch request valid |
| req_ready_o | output | 1 | Queue has space |
| req_slot_i | input | SLOT_W | Destination slot index |
| req_addr_i | input | ADDR_W | Byte address |
| req_type_i | input | 3 | Load width and sign code |
| mem_req_o | output | NUM_BANKS | Per-bank read strobe |
| mem_addr_o | output | NUM_BANKS*ADDR_W | Per-bank word-aligned read address |
| mem_ack_i | input | NUM_BANKS | Per-bank read acknowledge |
| mem_rdata_i | input | NUM_BANKS*32 | Per-bank read data |
| mem_err_i | input | NUM_BANKS | Per-bank access error, valid with acknowledge |
| rsp_valid_o | output | 1 | Completion valid |
| rsp_slot_o | output | SLOT_W | Completed slot |
| rsp_data_o | output | 32 | Extracted value |
| rsp_fault_o | output | 1 | Access faulted |

## Verification
The bench builds the block with three banks and a four-entry queue. Three banks make the bank index a true modulo rather than a bit slice, so wrong address-to-bank mapping shows up. The short queue fills quickly behind one deliberately slow bank, which exposes backpressure and same-bank ordering. Per-bank latencies are set per test. This lets a younger request overtake a blocked one, and lets two banks acknowledge in the same cycle to expose the completion priority.

// File: rtl/pf_sched_pkg.sv
package pf_sched_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    DT_WORD   = 3'd0,
    DT_HALF_U = 3'd1,
    DT_HALF_S = 3'd2,
    DT_BYTE_U = 3'd3,
    DT_BYTE_S = 3'd4
  } dtype_e;

  function automatic logic [WORD_W-1:0] pick_field(logic [WORD_W-1:0] w,
                                                   logic [1:0] off, logic [2:0] t);
    logic [15:0] h;
    logic [7:0]  b;
    h = off[1] ? w[31:16] : w[15:0];
    b = w[{off, 3'b000} +: 8];
    case (t)
      DT_HALF_U: pick_field = {16'h0000, h};
      DT_HALF_S: pick_field = {{16{h[15]}}, h};
      DT_BYTE_U: pick_field = {24'h000000, b};
      DT_BYTE_S: pick_field = {{24{b[7]}}, b};
      default:   pick_field = w;
    endcase
  endfunction

endpackage

// File: rtl/pf_sched_queue.sv
module pf_sched_queue #(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BANK_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic [SLOT_W-1:0]    push_slot_i,
  input  logic [ADDR_W-1:0]    push_addr_i,
  input  logic [2:0]           push_type_i,
  input  logic [BANK_W-1:0]    push_bank_i,
  input  logic [NUM_BANKS-1:0] bank_free_i,
  output logic                 full_o,
  output logic                 pop_valid_o,
  output logic [SLOT_W-1:0]    pop_slot_o,
  output logic [ADDR_W-1:0]    pop_addr_o,
  output logic [2:0]           pop_type_o,
  output logic [BANK_W-1:0]    pop_bank_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SLOT_W-1:0] slot_q [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [2:0]        type_q [DEPTH];
  logic [BANK_W-1:0] bank_q [DEPTH];
  logic [SLOT_W-1:0] slot_n [DEPTH];
  logic [ADDR_W-1:0] addr_n [DEPTH];
  logic [2:0]        type_n [DEPTH];
  logic [BANK_W-1:0] bank_n [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  sel;

  // index 0 is the oldest entry; the lowest eligible index wins
  always_comb begin
    pop_valid_o = 1'b0;
    sel         = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CNT_W'(i) < cnt_q && bank_free_i[bank_q[i]]) begin
        pop_valid_o = 1'b1;
        sel         = IDX_W'(i);
      end
    end
  end

  assign pop_slot_o = slot_q[sel];
  assign pop_addr_o = addr_q[sel];
  assign pop_type_o = type_q[sel];
  assign pop_bank_o = bank_q[sel];
  assign full_o     = (cnt_q == CNT_W'(DEPTH));

  // compact over the popped entry, then append at the tail
  always_comb begin
    slot_n = slot_q;
    addr_n = addr_q;
    type_n = type_q;
    bank_n = bank_q;
    cnt_n  = cnt_q;
    if (pop_valid_o) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= sel) begin
          slot_n[i] = slot_q[i+1];
          addr_n[i] = addr_q[i+1];
          type_n[i] = type_q[i+1];
          bank_n[i] = bank_q[i+1];
        end
      end
      cnt_n = cnt_q - 1'b1;
    end
    if (push_i) begin
      slot_n[cnt_n[IDX_W-1:0]] = push_slot_i;
      addr_n[cnt_n[IDX_W-1:0]] = push_addr_i;
      type_n[cnt_n[IDX_W-1:0]] = push_type_i;
      bank_n[cnt_n[IDX_W-1:0]] = push_bank_i;
      cnt_n = cnt_n + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  always_ff @(posedge clk_i) begin
    slot_q <= slot_n;
    addr_q <= addr_n;
    type_q <= type_n;
    bank_q <= bank_n;
  end

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  a_r5_one_leaves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o && !push_i |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/pf_sched_bank.sv
module pf_sched_bank
  import pf_sched_pkg::*;
#(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [SLOT_W-1:0] issue_slot_i,
  input  logic [ADDR_W-1:0] issue_addr_i,
  input  logic [2:0]        issue_type_i,
  output logic              free_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_err_i,
  input  logic              take_i,
  output logic              hold_o,
  output logic [SLOT_W-1:0] hold_slot_o,
  output logic [WORD_W-1:0] hold_data_o,
  output logic              hold_fault_o
);
  logic              req_q, busy_q, hold_q, fault_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SLOT_W-1:0] slot_q;
  logic [2:0]        type_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      busy_q  <= 1'b0;
      hold_q  <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
      slot_q  <= '0;
      type_q  <= '0;
      data_q  <= '0;
    end else begin
      req_q <= issue_i;
      if (issue_i) begin
        busy_q <= 1'b1;
        addr_q <= issue_addr_i;
        slot_q <= issue_slot_i;
        type_q <= issue_type_i;
      end
      if (busy_q && mem_ack_i) begin
        busy_q  <= 1'b0;
        hold_q  <= 1'b1;
        fault_q <= mem_err_i;
        data_q  <= mem_err_i ? '0 : pick_field(mem_rdata_i, addr_q[1:0], type_q);
      end
      if (take_i) hold_q <= 1'b0;
    end
  end

  assign free_o       = !busy_q && !hold_q;
  assign mem_req_o    = req_q;
  assign mem_addr_o   = {addr_q[ADDR_W-1:2], 2'b00};
  assign hold_o       = hold_q;
  assign hold_slot_o  = slot_q;
  assign hold_data_o  = data_q;
  assign hold_fault_o = fault_q;

  a_r3_issue_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> free_o);

  a_r3_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r6_take_needs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> hold_o);

  a_r6_result_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o && !take_i |=> hold_o && $stable(hold_data_o) && $stable(hold_slot_o));

endmodule

// File: rtl/pf_sched.sv
module pf_sched
  import pf_sched_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned QUEUE_DEPTH = 8,
  parameter int unsigned SLOT_W      = 5,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [SLOT_W-1:0]           req_slot_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [2:0]                  req_type_i,
  output logic [NUM_BANKS-1:0]        mem_req_o,
  output logic [NUM_BANKS*ADDR_W-1:0] mem_addr_o,
  input  logic [NUM_BANKS-1:0]        mem_ack_i,
  input  logic [NUM_BANKS*WORD_W-1:0] mem_rdata_i,
  input  logic [NUM_BANKS-1:0]        mem_err_i,
  output logic                        rsp_valid_o,
  output logic [SLOT_W-1:0]           rsp_slot_o,
  output logic [WORD_W-1:0]           rsp_data_o,
  output logic                        rsp_fault_o
);
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic                 full, push, pop_valid;
  logic [ADDR_W-3:0]    word_addr;
  logic [BANK_W-1:0]    push_bank, pop_bank;
  logic [SLOT_W-1:0]    pop_slot;
  logic [ADDR_W-1:0]    pop_addr;
  logic [2:0]           pop_type;
  logic [NUM_BANKS-1:0] bank_free, take, hold, hold_fault;
  logic [SLOT_W-1:0]    hold_slot [NUM_BANKS];
  logic [WORD_W-1:0]    hold_data [NUM_BANKS];

  assign word_addr   = req_addr_i[ADDR_W-1:2];
  assign push_bank   = BANK_W'(word_addr % (ADDR_W-2)'(NUM_BANKS));
  assign req_ready_o = !full;
  assign push        = req_valid_i && !full;

  pf_sched_queue #(
    .DEPTH(QUEUE_DEPTH), .NUM_BANKS(NUM_BANKS), .SLOT_W(SLOT_W),
    .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) i_queue (
    .clk_i, .rst_ni,
    .push_i(push), .push_slot_i(req_slot_i), .push_addr_i(req_addr_i),
    .push_type_i(req_type_i), .push_bank_i(push_bank),
    .bank_free_i(bank_free), .full_o(full),
    .pop_valid_o(pop_valid), .pop_slot_o(pop_slot), .pop_addr_o(pop_addr),
    .pop_type_o(pop_type), .pop_bank_o(pop_bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pf_sched_bank #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) i_bank (
      .clk_i, .rst_ni,
      .issue_i(pop_valid && pop_bank == BANK_W'(b)),
      .issue_slot_i(pop_slot), .issue_addr_i(pop_addr), .issue_type_i(pop_type),
      .free_o(bank_free[b]),
      .mem_req_o(mem_req_o[b]), .mem_addr_o(mem_addr_o[b*ADDR_W +: ADDR_W]),
      .mem_ack_i(mem_ack_i[b]), .mem_rdata_i(mem_rdata_i[b*WORD_W +: WORD_W]),
      .mem_err_i(mem_err_i[b]),
      .take_i(take[b]), .hold_o(hold[b]), .hold_slot_o(hold_slot[b]),
      .hold_data_o(hold_data[b]), .hold_fault_o(hold_fault[b])
    );
  end

  // fixed priority: lowest bank with a waiting result
  always_comb begin
    take        = '0;
    rsp_valid_o = 1'b0;
    rsp_slot_o  = '0;
    rsp_data_o  = '0;
    rsp_fault_o = 1'b0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (hold[b]) begin
        take        = '0;
        take[b]     = 1'b1;
        rsp_valid_o = 1'b1;
        rsp_slot_o  = hold_slot[b];
        rsp_data_o  = hold_data[b];
        rsp_fault_o = hold_fault[b];
      end
    end
  end

  a_r6_one_completion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take));

  a_r3_strobe_per_open_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mem_req_o) <= 1);

  a_r1_ready_after_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o && pop_valid |=> req_ready_o);

endmodule

// File: tb/test_pf_sched.sv
module test_pf_sched;
  localparam int NB = 3;
  localparam int QD = 4;
  localparam int SW = 5;
  localparam int AW = 32;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [SW-1:0]    req_slot = '0;
  logic [AW-1:0]    req_addr = '0;
  logic [2:0]       req_type = '0;
  logic [NB-1:0]    mem_req;
  logic [NB*AW-1:0] mem_addr;
  logic [NB-1:0]    mem_ack;
  logic [NB*32-1:0] mem_rdata;
  logic [NB-1:0]    mem_err;
  logic             rsp_valid, rsp_fault;
  logic [SW-1:0]    rsp_slot;
  logic [31:0]      rsp_data;

  pf_sched #(.NUM_BANKS(NB), .QUEUE_DEPTH(QD), .SLOT_W(SW), .ADDR_W(AW)) i_pf_sched (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_slot_i(req_slot),
    .req_addr_i(req_addr), .req_type_i(req_type),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .rsp_valid_o(rsp_valid), .rsp_slot_o(rsp_slot), .rsp_data_o(rsp_data),
    .rsp_fault_o(rsp_fault)
  );

  int checks = 0;
  int fails = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mdata(logic [31:0] a);
    return {8'h53, a[9:2] ^ 8'hA0, 8'h9A, 8'h47};
  endfunction

  function automatic logic [31:0] exp_data(logic [31:0] a, logic [2:0] t);
    logic [31:0] w;
    logic [7:0]  by;
    logic [15:0] hw;
    w  = mdata(a);
    by = (w >> (8 * a[1:0])) & 32'hFF;
    hw = a[1] ? w[31:16] : w[15:0];
    if (a[16]) return 32'h0;
    case (t)
      3'd1: return {16'h0, hw};
      3'd2: return hw[15] ? {16'hFFFF, hw} : {16'h0, hw};
      3'd3: return {24'h0, by};
      3'd4: return by[7] ? {24'hFFFFFF, by} : {24'h0, by};
      default: return w;
    endcase
  endfunction

  // memory bank models
  int          lat [NB];
  logic        pend [NB];
  int          cnt [NB];
  logic [31:0] laddr [NB];
  logic [31:0] iss_log [256];
  int          iss_n = 0;
  int          r2_err = 0;
  int          r3_err = 0;
  int          max_out = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        pend[b] <= 1'b0; cnt[b] <= 0; laddr[b] <= '0;
      end
      mem_ack <= '0; mem_rdata <= '0; mem_err <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        mem_ack[b] <= 1'b0;
        if (mem_req[b]) begin
          logic [31:0] a;
          a = mem_addr[b*AW +: AW];
          if (pend[b]) r3_err++;
          if (a[1:0] != 2'b00) r3_err++;
          if (int'((a >> 2) % NB) != b) r2_err++;
          iss_log[iss_n % 256] = a;
          iss_n++;
          pend[b] <= 1'b1; cnt[b] <= lat[b]; laddr[b] <= a;
        end else if (pend[b]) begin
          if (cnt[b] <= 1) begin
            mem_ack[b] <= 1'b1;
            mem_rdata[b*32 +: 32] <= mdata(laddr[b]);
            mem_err[b] <= laddr[b][16];
            pend[b] <= 1'b0;
          end else cnt[b] <= cnt[b] - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    int n;
    n = 0;
    for (int b = 0; b < NB; b++) if (pend[b]) n++;
    if (n > max_out) max_out = n;
  end

  // completion log
  logic [SW-1:0] rs_slot [256];
  logic [31:0]   rs_data [256];
  logic          rs_fault [256];
  int            rs_n = 0;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      rs_slot[rs_n % 256] = rsp_slot;
      rs_data[rs_n % 256] = rsp_data;
      rs_fault[rs_n % 256] = rsp_fault;
      rs_n++;
    end
  end

  function automatic int rsp_pos(int slot, int from);
    for (int i = from; i < rs_n; i++) if (int'(rs_slot[i % 256]) == slot) return i;
    return -1;
  endfunction

  function automatic int iss_pos(logic [31:0] a, int from);
    for (int i = from; i < iss_n; i++) if (iss_log[i % 256] == {a[31:2], 2'b00}) return i;
    return -1;
  endfunction

  task automatic push(int slot, logic [31:0] a, logic [2:0] t);
    @(negedge clk);
    req_valid = 1'b1; req_slot = SW'(slot); req_addr = a; req_type = t;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain(int target);
    for (int i = 0; i < 2000 && rs_n < target; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(rs_n == target, "R6", "completion count", rs_n, target);
  endtask

  task automatic set_lat(int l0, int l1, int l2);
    lat[0] = l0; lat[1] = l1; lat[2] = l2;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // slot, address, type code
  localparam logic [SW+AW+3-1:0] VEC [NV] = '{
    {5'd1,  32'h0000_0100, 3'd0},
    {5'd2,  32'h0000_0106, 3'd1},
    {5'd3,  32'h0000_010A, 3'd2},
    {5'd4,  32'h0000_010C, 3'd2},
    {5'd5,  32'h0000_0111, 3'd3},
    {5'd6,  32'h0000_0113, 3'd4},
    {5'd7,  32'h0000_0116, 3'd4},
    {5'd8,  32'h0001_0000, 3'd0},
    {5'd9,  32'h0000_0117, 3'd7},
    {5'd10, 32'h0000_011C, 3'd3}
  };

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base, p, q, pa, pb, pc;
    set_lat(2, 2, 2);
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9", "ready in reset", req_ready, 1);
    check(mem_req == '0, "R9", "mem_req in reset", mem_req, 0);
    check(rsp_valid == 1'b0, "R9", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && mem_req == '0 && rsp_valid == 1'b0, "R9",
          "idle after reset", {req_ready, mem_req, rsp_valid}, 5'b10000);

    // table walk: R7 extraction, R8 fault, R6 completion contents
    base = rs_n;
    for (int v = 0; v < NV; v++)
      push(int'(VEC[v][AW+3 +: SW]), VEC[v][3 +: AW], VEC[v][2:0]);
    drain(base + NV);
    for (int v = 0; v < NV; v++) begin
      logic [31:0] a;
      logic [2:0]  t;
      int          s;
      s = int'(VEC[v][AW+3 +: SW]); a = VEC[v][3 +: AW]; t = VEC[v][2:0];
      p = rsp_pos(s, base);
      check(p >= 0, "R6", $sformatf("slot %0d returned", s), p, 0);
      if (p >= 0) begin
        check(rs_data[p % 256] == exp_data(a, t), a[16] ? "R8" : "R7",
              $sformatf("data slot %0d", s), rs_data[p % 256], exp_data(a, t));
        check(rs_fault[p % 256] == a[16], "R8", $sformatf("fault slot %0d", s),
              rs_fault[p % 256], a[16]);
      end
    end
    check(max_out >= 2, "R4", "banks open at once", max_out, 2);

    // R1 backpressure behind a slow bank 0, R5 same-bank order
    set_lat(40, 2, 2);
    base = rs_n;
    push(11, 32'h300, 3'd0);
    push(12, 32'h30C, 3'd0);
    push(13, 32'h318, 3'd0);
    push(14, 32'h324, 3'd0);
    push(15, 32'h330, 3'd0);
    repeat (2) @(negedge clk);
    check(req_ready == 1'b0, "R1", "ready low when full", req_ready, 0);
    push(16, 32'h33C, 3'd0);
    drain(base + 6);
    for (int k = 0; k < 6; k++)
      check(int'(rs_slot[(base + k) % 256]) == 11 + k, "R5", "same-bank order",
            rs_slot[(base + k) % 256], 11 + k);
    check(rs_data[(base + 5) % 256] == mdata(32'h33C), "R1", "held request served",
          rs_data[(base + 5) % 256], mdata(32'h33C));

    // R5 younger request to an idle bank passes a blocked one
    set_lat(30, 2, 2);
    base = rs_n;
    q = iss_n;
    push(20, 32'h600, 3'd0);
    push(21, 32'h60C, 3'd0);
    push(22, 32'h604, 3'd0);
    drain(base + 3);
    pb = iss_pos(32'h60C, q);
    pc = iss_pos(32'h604, q);
    check(pc >= 0 && pc < pb, "R5", "bypass issue order", pc, pb);
    pa = rsp_pos(20, base);
    pb = rsp_pos(21, base);
    pc = rsp_pos(22, base);
    check(pc < pa && pa < pb, "R5", "bypass completion order", {pc[7:0], pa[7:0], pb[7:0]}, 24'h000102);

    // R6 bank 0 wins when two results arrive together
    set_lat(3, 2, 2);
    base = rs_n;
    push(23, 32'h900, 3'd0);
    push(24, 32'h904, 3'd0);
    drain(base + 2);
    check(int'(rs_slot[base % 256]) == 23, "R6", "lowest bank first", rs_slot[base % 256], 23);
    check(int'(rs_slot[(base + 1) % 256]) == 24, "R6", "second bank next",
          rs_slot[(base + 1) % 256], 24);

    check(r2_err == 0, "R2", "bank mapping errors", r2_err, 0);
    check(r3_err == 0, "R3", "overlapping or unaligned reads", r3_err, 0);
    finish_run();
  end

endmodule